// File: doc/BRIEF.md
# Way-Lockable Set-Associative Read Cache

This block is a unified cache between a processor-side read port and a slower next-level memory. It is indexed and tagged with physical addresses. Tags, valid bits and line data are stored per set and per way. Each request gives a lookup result one cycle after it is accepted. A hit returns its 64-bit word in that same cycle. A miss hands the line address to a fill engine. The fill engine fetches the whole 32-byte line as four 64-bit beats and writes it into a victim way. It then returns the word that was asked for.

A lockdown input, one bit per way, removes ways from the replacement choice. Software can therefore shrink the cache from eight-way operation down to a single way, which behaves as direct-mapped. Software can also lock every way, which makes misses pass through uncached. Lines already held in a locked way stay valid and still hit. The block has no snooping, so software keeps coherency. No parity is stored.

Top module: `waylock_cache`

## Requirements
- R1: For a request accepted on a clock edge, `look_valid` is high in the following cycle, with `look_hit` and, on a hit, `look_way`. On a hit, `rsp_valid` is high and `rsp_data` holds the 64-bit word selected by address bits [4:3], all in that same cycle.
- R2: A miss raises `mem_req_valid` with the line address, which is the request address with bits [4:0] cleared. The request is held stable until `mem_req_ready`. The fill engine then takes exactly four `mem_rvalid` beats, and beat k carries line bytes 8k to 8k+7. A hit issues no memory request.
- R3: The cycle after the fourth beat is taken, `rsp_valid` is high and `rsp_data` holds the requested word. `look_hit` for that request was low.
- R4: On a miss, the lowest-numbered way in the set that is both invalid and unlocked is chosen as victim. No address is ever held in two ways of one set.
- R5: When every unlocked way in the set is valid, the victim is the first unlocked way at or above a shared pointer, wrapping from way 7 to way 0. The pointer is 0 after reset and becomes (victim + 1) mod 8 after each allocation.
- R6: A way whose `lock_mask` bit is 1 is never allocated. The mask value used is the one present in the lookup cycle of the miss.
- R7: With all eight lock bits set, a miss still returns its data, but `rsp_alloc` is 0 and nothing is written. A repeat of the same address misses again.
- R8: Lines already present in locked ways continue to hit.
- R9: `req_ready` is low from the lookup cycle of a miss until the miss response has been given. Hits can be accepted on consecutive cycles.
- R10: After reset, every line is invalid, `req_ready` is 1, and `look_valid`, `rsp_valid` and `mem_req_valid` are 0.
- R11: With seven ways locked, two lines that map to the same set keep evicting each other from the one unlocked way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lock_mask | input | WAYS | 1 = way excluded from replacement |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Request can be accepted |
| req_addr | input | ADDR_W | Physical byte address |
| look_valid | output | 1 | Lookup result valid |
| look_hit | output | 1 | Lookup hit |
| look_way | output | $clog2(WAYS) | Way that hit |
| rsp_valid | output | 1 | Read data valid |
| rsp_data | output | BEAT_W | Requested 64-bit word |
| rsp_filled | output | 1 | Response comes from a line fill |
| rsp_alloc | output | 1 | Fill was allocated into the cache |
| rsp_way | output | $clog2(WAYS) | Way of the response (hit way or victim) |
| mem_req_valid | output | 1 | Line fill request |
| mem_req_ready | input | 1 | Memory accepts the fill request |
| mem_req_addr | output | ADDR_W | Line-aligned fill address |
| mem_rvalid | input | 1 | Fill beat valid |
| mem_rdata | input | BEAT_W | Fill beat data |

## Verification
The hardest state to reach from the ports is a set that is completely full while the replacement pointer sits on a locked way. Only there does the wrap-around skip of locked ways decide the victim. The stimulus first fills one set with eight distinct tags, so the pointer has walked a known path. It then forces two round-robin evictions and changes the lock mask just as the pointer reaches a locked way. Afterwards it locks seven ways and then all eight, so that direct-mapped thrashing and uncached pass-through follow on the same, already known, set contents.

// File: rtl/wlc_pkg.sv
package wlc_pkg;

  typedef enum logic [1:0] {
    FS_IDLE  = 2'd0,
    FS_ASK   = 2'd1,
    FS_BEATS = 2'd2,
    FS_DONE  = 2'd3
  } fill_state_e;

endpackage

// File: rtl/wlc_tag_store.sv
module wlc_tag_store #(
  parameter int SETS  = 8,
  parameter int WAYS  = 8,
  parameter int TAG_W = 24
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [$clog2(SETS)-1:0]    rd_idx,
  input  logic [TAG_W-1:0]           rd_tag,
  output logic                       hit_any,
  output logic [$clog2(WAYS)-1:0]    hit_way,
  output logic [WAYS-1:0]            valid_row,
  input  logic                       wr_en,
  input  logic [$clog2(SETS)-1:0]    wr_idx,
  input  logic [$clog2(WAYS)-1:0]    wr_way,
  input  logic [TAG_W-1:0]           wr_tag
);
  localparam int WAY_W = $clog2(WAYS);

  logic [TAG_W-1:0] tag_q [SETS][WAYS];
  logic [WAYS-1:0]  vld_q [SETS];
  logic [WAYS-1:0]  hit_vec;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = vld_q[rd_idx][w] && (tag_q[rd_idx][w] == rd_tag);
  end

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hit_vec[w]) hit_way = hit_way | WAY_W'(w);
    end
  end

  assign hit_any   = |hit_vec;
  assign valid_row = vld_q[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
    end else if (wr_en) begin
      vld_q[wr_idx][wr_way] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) tag_q[wr_idx][wr_way] <= wr_tag;
  end

  AST_ONE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec)); // R4

endmodule

// File: rtl/wlc_data_store.sv
module wlc_data_store #(
  parameter int SETS   = 8,
  parameter int WAYS   = 8,
  parameter int BEATS  = 4,
  parameter int BEAT_W = 64
) (
  input  logic                       clk,
  input  logic [$clog2(SETS)-1:0]    rd_idx,
  input  logic [$clog2(WAYS)-1:0]    rd_way,
  input  logic [$clog2(BEATS)-1:0]   rd_beat,
  output logic [BEAT_W-1:0]          rd_data,
  input  logic                       wr_en,
  input  logic [$clog2(SETS)-1:0]    wr_idx,
  input  logic [$clog2(WAYS)-1:0]    wr_way,
  input  logic [$clog2(BEATS)-1:0]   wr_beat,
  input  logic [BEAT_W-1:0]          wr_data
);
  logic [BEAT_W-1:0] word_q [SETS][WAYS][BEATS];

  assign rd_data = word_q[rd_idx][rd_way][rd_beat];

  always_ff @(posedge clk) begin
    if (wr_en) word_q[wr_idx][wr_way][wr_beat] <= wr_data;
  end

endmodule

// File: rtl/wlc_victim.sv
module wlc_victim #(
  parameter int WAYS = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [WAYS-1:0]          valid_row,
  input  logic [WAYS-1:0]          lock,
  input  logic                     adv,
  input  logic [$clog2(WAYS)-1:0]  adv_way,
  output logic                     found,
  output logic [$clog2(WAYS)-1:0]  victim
);
  localparam int WAY_W = $clog2(WAYS);

  logic [WAY_W-1:0] ptr_q;

  // {found, way}: first invalid unlocked way, else first unlocked at or above ptr
  function automatic logic [WAY_W:0] choose(input logic [WAYS-1:0] v,
                                            input logic [WAYS-1:0] l,
                                            input logic [WAY_W-1:0] p);
    logic [WAY_W:0]   r;
    logic [WAY_W-1:0] c;
    r = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (!r[WAY_W] && !l[i] && !v[i]) r = {1'b1, WAY_W'(i)};
    end
    for (int k = 0; k < WAYS; k++) begin
      c = p + WAY_W'(k);
      if (!r[WAY_W] && !l[c]) r = {1'b1, c};
    end
    return r;
  endfunction

  always_comb begin
    {found, victim} = choose(valid_row, lock, ptr_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   ptr_q <= '0;
    else if (adv) ptr_q <= adv_way + 1'b1;
  end

endmodule

// File: rtl/wlc_fill_engine.sv
module wlc_fill_engine
  import wlc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 5,
  parameter int BEATS  = 4,
  parameter int BEAT_W = 64,
  parameter int WAYS   = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic [ADDR_W-OFF_W-1:0]      start_line,
  input  logic [$clog2(BEATS)-1:0]     start_beat,
  input  logic                         start_alloc,
  input  logic [$clog2(WAYS)-1:0]      start_way,
  output logic                         busy,
  output logic                         mem_req_valid,
  input  logic                         mem_req_ready,
  output logic [ADDR_W-1:0]            mem_req_addr,
  input  logic                         mem_rvalid,
  input  logic [BEAT_W-1:0]            mem_rdata,
  output logic                         wr_beat_en,
  output logic                         wr_last,
  output logic [$clog2(BEATS)-1:0]     wr_beat,
  output logic [ADDR_W-OFF_W-1:0]      cur_line,
  output logic [$clog2(WAYS)-1:0]      cur_way,
  output logic                         rsp_valid,
  output logic [BEAT_W-1:0]            rsp_data,
  output logic                         rsp_alloc
);
  localparam int LINE_W = ADDR_W - OFF_W;
  localparam int BSEL_W = $clog2(BEATS);
  localparam logic [BSEL_W-1:0] LAST_BEAT = BSEL_W'(BEATS - 1);

  fill_state_e         state_q;
  logic [LINE_W-1:0]   line_q;
  logic [BSEL_W-1:0]   beat_q;
  logic [BSEL_W-1:0]   cnt_q;
  logic                alloc_q;
  logic [$clog2(WAYS)-1:0] way_q;
  logic [BEAT_W-1:0]   hold_q;
  logic                take_beat;

  function automatic logic [ADDR_W-1:0] line_base(input logic [LINE_W-1:0] ln);
    return {ln, {OFF_W{1'b0}}};
  endfunction

  assign take_beat     = (state_q == FS_BEATS) && mem_rvalid;
  assign busy          = (state_q != FS_IDLE);
  assign mem_req_valid = (state_q == FS_ASK);
  assign mem_req_addr  = line_base(line_q);
  assign wr_beat_en    = take_beat && alloc_q;
  assign wr_last       = wr_beat_en && (cnt_q == LAST_BEAT);
  assign wr_beat       = cnt_q;
  assign cur_line      = line_q;
  assign cur_way       = way_q;
  assign rsp_valid     = (state_q == FS_DONE);
  assign rsp_data      = hold_q;
  assign rsp_alloc     = rsp_valid && alloc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= FS_IDLE;
      line_q  <= '0;
      beat_q  <= '0;
      cnt_q   <= '0;
      alloc_q <= 1'b0;
      way_q   <= '0;
      hold_q  <= '0;
    end else begin
      case (state_q)
        FS_IDLE: if (start) begin
          line_q  <= start_line;
          beat_q  <= start_beat;
          alloc_q <= start_alloc;
          way_q   <= start_way;
          cnt_q   <= '0;
          state_q <= FS_ASK;
        end
        FS_ASK: if (mem_req_ready) state_q <= FS_BEATS;
        FS_BEATS: if (mem_rvalid) begin
          if (cnt_q == beat_q) hold_q <= mem_rdata;
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST_BEAT) state_q <= FS_DONE;
        end
        default: state_q <= FS_IDLE;
      endcase
    end
  end

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R2
  AST_FOUR_BEATS: assert property (@(posedge clk) disable iff (!rst_n)
    take_beat && (cnt_q == LAST_BEAT) |=> rsp_valid); // R3
  AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start); // R9

endmodule

// File: rtl/waylock_cache.sv
module waylock_cache
  import wlc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int SETS       = 8,
  parameter int WAYS       = 8,
  parameter int LINE_BYTES = 32,
  parameter int BEAT_W     = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [WAYS-1:0]            lock_mask,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [ADDR_W-1:0]          req_addr,
  output logic                       look_valid,
  output logic                       look_hit,
  output logic [$clog2(WAYS)-1:0]    look_way,
  output logic                       rsp_valid,
  output logic [BEAT_W-1:0]          rsp_data,
  output logic                       rsp_filled,
  output logic                       rsp_alloc,
  output logic [$clog2(WAYS)-1:0]    rsp_way,
  output logic                       mem_req_valid,
  input  logic                       mem_req_ready,
  output logic [ADDR_W-1:0]          mem_req_addr,
  input  logic                       mem_rvalid,
  input  logic [BEAT_W-1:0]          mem_rdata
);
  localparam int WAY_W      = $clog2(WAYS);
  localparam int BEAT_BYTES = BEAT_W / 8;
  localparam int BEATS      = LINE_BYTES / BEAT_BYTES;
  localparam int OFF_W      = $clog2(LINE_BYTES);
  localparam int BOFF_W     = $clog2(BEAT_BYTES);
  localparam int BSEL_W     = $clog2(BEATS);
  localparam int IDX_W      = $clog2(SETS);
  localparam int TAG_W      = ADDR_W - IDX_W - OFF_W;
  localparam int LINE_W     = ADDR_W - OFF_W;

  // lookup stage
  logic              s1_valid;
  logic [TAG_W-1:0]  s1_tag;
  logic [IDX_W-1:0]  s1_idx;
  logic [BSEL_W-1:0] s1_beat;
  logic              accept;
  logic              unused_low;

  // events between pieces
  logic              hit_any;
  logic [WAY_W-1:0]  hit_way;
  logic [WAYS-1:0]   valid_row;
  logic              vic_found;
  logic [WAY_W-1:0]  vic_way;
  logic              miss_start;
  logic [WAYS-1:0]   miss_lock_q;

  logic              fe_busy;
  logic              fe_wr_beat;
  logic              fe_wr_last;
  logic [BSEL_W-1:0] fe_wr_sel;
  logic [LINE_W-1:0] fe_line;
  logic [WAY_W-1:0]  fe_way;
  logic              fe_rsp_valid;
  logic [BEAT_W-1:0] fe_rsp_data;
  logic              fe_rsp_alloc;
  logic [BEAT_W-1:0] ds_rd_data;

  assign unused_low = ^req_addr[BOFF_W-1:0];
  assign accept     = req_valid && req_ready;
  assign miss_start = s1_valid && !hit_any;
  assign req_ready  = !fe_busy && !miss_start;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_tag   <= '0;
      s1_idx   <= '0;
      s1_beat  <= '0;
    end else begin
      s1_valid <= accept;
      if (accept) begin
        s1_tag  <= req_addr[ADDR_W-1 -: TAG_W];
        s1_idx  <= req_addr[OFF_W +: IDX_W];
        s1_beat <= req_addr[BOFF_W +: BSEL_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          miss_lock_q <= '0;
    else if (miss_start) miss_lock_q <= lock_mask;
  end

  wlc_tag_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_tags (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_idx    (s1_idx),
    .rd_tag    (s1_tag),
    .hit_any   (hit_any),
    .hit_way   (hit_way),
    .valid_row (valid_row),
    .wr_en     (fe_wr_last),
    .wr_idx    (fe_line[IDX_W-1:0]),
    .wr_way    (fe_way),
    .wr_tag    (fe_line[LINE_W-1 -: TAG_W])
  );

  wlc_data_store #(.SETS(SETS), .WAYS(WAYS), .BEATS(BEATS), .BEAT_W(BEAT_W)) u_data (
    .clk     (clk),
    .rd_idx  (s1_idx),
    .rd_way  (hit_way),
    .rd_beat (s1_beat),
    .rd_data (ds_rd_data),
    .wr_en   (fe_wr_beat),
    .wr_idx  (fe_line[IDX_W-1:0]),
    .wr_way  (fe_way),
    .wr_beat (fe_wr_sel),
    .wr_data (mem_rdata)
  );

  wlc_victim #(.WAYS(WAYS)) u_victim (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_row (valid_row),
    .lock      (lock_mask),
    .adv       (fe_wr_last),
    .adv_way   (fe_way),
    .found     (vic_found),
    .victim    (vic_way)
  );

  wlc_fill_engine #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .BEATS(BEATS),
                    .BEAT_W(BEAT_W), .WAYS(WAYS)) u_fill (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (miss_start),
    .start_line    ({s1_tag, s1_idx}),
    .start_beat    (s1_beat),
    .start_alloc   (vic_found),
    .start_way     (vic_way),
    .busy          (fe_busy),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rvalid    (mem_rvalid),
    .mem_rdata     (mem_rdata),
    .wr_beat_en    (fe_wr_beat),
    .wr_last       (fe_wr_last),
    .wr_beat       (fe_wr_sel),
    .cur_line      (fe_line),
    .cur_way       (fe_way),
    .rsp_valid     (fe_rsp_valid),
    .rsp_data      (fe_rsp_data),
    .rsp_alloc     (fe_rsp_alloc)
  );

  assign look_valid = s1_valid;
  assign look_hit   = s1_valid && hit_any;
  assign look_way   = hit_way;
  assign rsp_valid  = look_hit || fe_rsp_valid;
  assign rsp_data   = fe_rsp_valid ? fe_rsp_data : ds_rd_data;
  assign rsp_filled = fe_rsp_valid;
  assign rsp_alloc  = fe_rsp_alloc;
  assign rsp_way    = fe_rsp_valid ? fe_way : hit_way;

  AST_LOOK_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> look_valid); // R1
  AST_STALL_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    look_valid && !look_hit |=> !req_ready); // R9
  AST_ALLOC_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    fe_wr_last |-> !miss_lock_q[fe_way]); // R6
  AST_ALL_LOCKED_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    miss_start && (&lock_mask) |-> !vic_found); // R7
  AST_RSP_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    fe_rsp_valid |-> !s1_valid); // R3

endmodule

// File: tb/waylock_cache_tb.sv
module waylock_cache_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  lock_mask;
  logic        req_valid;
  logic        req_ready;
  logic [31:0] req_addr;
  logic        look_valid, look_hit;
  logic [2:0]  look_way;
  logic        rsp_valid;
  logic [63:0] rsp_data;
  logic        rsp_filled, rsp_alloc;
  logic [2:0]  rsp_way;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic [31:0] mem_req_addr;
  logic        mem_rvalid;
  logic [63:0] mem_rdata;

  int n_chk = 0;
  int n_fail = 0;
  int fills = 0;
  logic [31:0] last_fill = '0;
  bit finished = 0;

  always #10 clk = ~clk;

  waylock_cache u_dut (
    .clk(clk), .rst_n(rst_n), .lock_mask(lock_mask),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .look_valid(look_valid), .look_hit(look_hit), .look_way(look_way),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_filled(rsp_filled),
    .rsp_alloc(rsp_alloc), .rsp_way(rsp_way),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  function automatic logic [63:0] mem_word(input logic [31:0] line, input int b);
    return {line, 16'h5A00, 14'd0, 2'(b)};
  endfunction

  function automatic logic [31:0] adr(input int tag, input int set, input int beat);
    return {24'(tag), 3'(set), 2'(beat), 3'b000};
  endfunction

  // [44:13] addr, [12:5] lock, [4] hit, [3:1] way, [0] alloc
  function automatic logic [44:0] mk(input int tag, input int set, input int beat,
                                     input int lk, input int h, input int w, input int a);
    return {adr(tag, set, beat), 8'(lk), 1'(h), 3'(w), 1'(a)};
  endfunction

  localparam int NVEC = 27;
  localparam logic [44:0] VEC [NVEC] = '{
    mk(1, 1, 0, 8'h00, 0, 0, 1),   // R4 empty set, way0
    mk(1, 1, 2, 8'h00, 1, 0, 0),   // R1 hit
    mk(2, 1, 1, 8'h00, 0, 1, 1),
    mk(3, 1, 3, 8'h00, 0, 2, 1),
    mk(4, 1, 0, 8'h00, 0, 3, 1),
    mk(5, 1, 1, 8'h00, 0, 4, 1),
    mk(6, 1, 2, 8'h00, 0, 5, 1),
    mk(7, 1, 3, 8'h00, 0, 6, 1),
    mk(8, 1, 0, 8'h00, 0, 7, 1),   // set full, pointer 0
    mk(9, 1, 1, 8'h00, 0, 0, 1),   // R5 round robin
    mk(1, 1, 2, 8'h00, 0, 1, 1),   // R5 evicted line refetched
    mk(9, 1, 3, 8'h00, 1, 0, 0),
    mk(3, 1, 0, 8'h00, 1, 2, 0),
    mk(10, 1, 1, 8'h04, 0, 3, 1),  // R6 pointer on locked way2
    mk(3, 1, 2, 8'h04, 1, 2, 0),   // R8 locked way hits
    mk(11, 1, 0, 8'hFE, 0, 0, 1),  // R11 direct mapped
    mk(12, 1, 1, 8'hFE, 0, 0, 1),
    mk(11, 1, 2, 8'hFE, 0, 0, 1),
    mk(12, 1, 3, 8'hFE, 0, 0, 1),
    mk(10, 1, 0, 8'hFE, 1, 3, 0),  // R8
    mk(13, 1, 1, 8'hFF, 0, 0, 0),  // R7 uncached
    mk(13, 1, 2, 8'hFF, 0, 0, 0),  // R7 misses again
    mk(12, 1, 0, 8'hFF, 1, 0, 0),
    mk(1, 2, 0, 8'h00, 0, 0, 1),   // R4 invalid beats pointer
    mk(2, 2, 1, 8'h00, 0, 1, 1),
    mk(5, 3, 0, 8'h01, 0, 1, 1),   // R4 lowest invalid unlocked
    mk(6, 3, 0, 8'h01, 0, 2, 1)
  };

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp,
                     input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // next-level memory model: ready always, four beats after one idle cycle
  initial begin
    mem_rvalid = 1'b0;
    mem_rdata  = '0;
    forever begin
      @(negedge clk);
      if (mem_req_valid) begin
        logic [31:0] line;
        line = mem_req_addr;
        fills++;
        last_fill = line;
        @(negedge clk);
        for (int b = 0; b < 4; b++) begin
          mem_rvalid = 1'b1;
          mem_rdata  = mem_word(line, b);
          @(negedge clk);
        end
        mem_rvalid = 1'b0;
      end
    end
  end

  task automatic access(input logic [31:0] a, input logic [7:0] lk, input logic eh,
                        input logic [2:0] ew, input logic ea, input string rq);
    int f0;
    int w;
    logic [31:0] base;
    base = {a[31:5], 5'b0};
    lock_mask = lk;
    w = 0;
    while (!req_ready && w < 50) begin @(negedge clk); w++; end
    f0 = fills;
    req_valid = 1'b1;
    req_addr  = a;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R1", 64'(look_valid), 64'd1, "look_valid");
    chk(rq, 64'(look_hit), 64'(eh), "look_hit");
    if (eh) begin
      chk("R1", 64'(look_way), 64'(ew), "hit way");
      chk("R1", 64'(rsp_valid), 64'd1, "hit rsp_valid");
      chk("R1", rsp_data, mem_word(base, int'(a[4:3])), "hit data");
      chk("R2", 64'(fills), 64'(f0), "no fill on hit");
    end else begin
      chk("R9", 64'(req_ready), 64'd0, "ready low on miss");
      w = 0;
      while (!rsp_valid && w < 40) begin @(negedge clk); w++; end
      chk("R3", 64'(rsp_valid), 64'd1, "miss rsp_valid");
      chk("R3", rsp_data, mem_word(base, int'(a[4:3])), "miss data");
      chk("R7", 64'(rsp_alloc), 64'(ea), "alloc flag");
      if (ea) chk("R5", 64'(rsp_way), 64'(ew), "victim way");
      chk("R2", 64'(fills), 64'(f0 + 1), "one fill");
      chk("R2", 64'(last_fill), 64'(base), "fill address");
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      report();
    end
  end

  initial begin
    rst_n = 1'b0;
    lock_mask = '0;
    req_valid = 1'b0;
    req_addr = '0;
    mem_req_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10", 64'(req_ready), 64'd1, "req_ready");
    chk("R10", 64'(look_valid), 64'd0, "look_valid");
    chk("R10", 64'(rsp_valid), 64'd0, "rsp_valid");
    chk("R10", 64'(mem_req_valid), 64'd0, "mem_req_valid");

    for (int i = 0; i < NVEC; i++) begin
      logic [44:0] v;
      string rq;
      v = VEC[i];
      if (v[4])       rq = "R8";
      else if (!v[0]) rq = "R7";
      else            rq = "R5";
      access(v[44:13], v[12:5], v[4], v[3:1], v[0], rq);
    end

    // R9 back-to-back hits in set 2
    lock_mask = '0;
    req_valid = 1'b1;
    req_addr  = adr(1, 2, 3);
    @(negedge clk);
    chk("R9", 64'(look_hit), 64'd1, "first hit");
    chk("R9", 64'(look_way), 64'd0, "first way");
    chk("R9", 64'(req_ready), 64'd1, "ready during hit");
    req_addr = adr(2, 2, 2);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9", 64'(look_hit), 64'd1, "second hit");
    chk("R9", 64'(look_way), 64'd1, "second way");
    chk("R9", rsp_data, mem_word(adr(2, 2, 0), 2), "second data");
    @(negedge clk);

    // R10 reset clears all lines
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    access(adr(12, 1, 1), 8'h00, 1'b0, 3'd0, 1'b1, "R10");

    finished = 1;
    report();
  end

endmodule